// File: doc/BRIEF.md
# Reset Delay and Low-Power Mode Controller

This block sits beside a small 8-bit processor core and decides when the core may run. It holds the core in reset for a fixed delay after the supply becomes good, after a watchdog timeout, or after a wake from stop mode. The delay is measured in ticks of a dedicated slow RC oscillator. The controller runs on a free-running control clock. The slow oscillator reaches it as a single-cycle `slowTick` strobe that has already been synchronised to that clock.

The block also watches the opcode stream of the core for the two sleep instructions. Each one counts only when the valid opcode just before it was a NOP. Halt gates off the CPU clock and leaves the main oscillator running, so timers and interrupt lines stay alive; an enabled interrupt resumes execution without a reset. Stop turns off the CPU clock and the oscillator enable. Interrupts cannot end stop; only a reset source can. Every exit from stop restarts the core at the stop-recovery vector instead of the cold vector.

A register bit chooses what happens on stop recovery. Either the full delay runs, or the core gets a single-cycle reset and starts at once. The state is visible as a one-hot vector.

Top module: `rstsleep_ctrl`

## Requirements
- R1: While `porN` is low, `coreReset`=1, `cpuClkEn`=1, `oscEn`=1, `stateOh`=4'b1000 (bit0 run, bit1 halt, bit2 stop, bit3 reset-wait) and `restartAddr`=16'h0000.
- R2: In reset-wait, `coreReset` stays high until TERM = SLOW_HZ*DELAY_US/1e6 slow ticks have been counted. It falls at the control-clock edge that follows the edge on which the TERM-th tick was taken.
- R3: While `powerGood` is low, the block holds reset-wait with the count at zero and ignores ticks, and selects the cold vector 16'h0000. The delay starts counting once `powerGood` is high again.
- R4: A `wdtTimeout` pulse enters reset-wait and runs the full delay. The vector is 16'h0000 when the pulse arrives in run or halt, and 16'h000C when it arrives in stop.
- R5: A `wdtTimeout` pulse during reset-wait restarts the count from zero, so TERM further ticks are needed.
- R6: In run, a valid opcode 8'h7F whose preceding valid opcode was 8'hFF enters halt on that edge: `cpuClkEn`=0, `oscEn`=1, `stateOh`=4'b0010.
- R7: In run, a valid opcode 8'h6F whose preceding valid opcode was 8'hFF enters stop on that edge: `cpuClkEn`=0, `oscEn`=0, `stateOh`=4'b0100.
- R8: An 8'h7F or 8'h6F whose preceding valid opcode was not 8'hFF is ignored, and the block stays in run.
- R9: Halt ends on the edge where some `irqReq[i]` & `irqEn[i]` is high and `intEnable` is high. The block returns to run with no reset and an unchanged vector. Masked requests leave it in halt.
- R10: In stop, interrupt requests have no effect, even when they are enabled.
- R11: `stopRecover` in stop selects vector 16'h000C. With `stopDelayEn`=1 the full delay runs. With `stopDelayEn`=0, `coreReset` is high for exactly one control cycle before run.
- R12: `extReset` high holds reset-wait, and run follows on the first edge at which it is seen low, with no slow-tick delay. The vector becomes 16'h000C if the reset began in stop and 16'h0000 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running control clock |
| porN | input | 1 | Asynchronous power-on reset of the controller, active low |
| powerGood | input | 1 | Supply monitor output, high when the supply is usable |
| extReset | input | 1 | External reset request, active high |
| wdtTimeout | input | 1 | Watchdog timeout pulse |
| stopRecover | input | 1 | Stop-mode recovery event |
| stopDelayEn | input | 1 | Stop-mode register bit 5: 1 runs the delay after stop recovery |
| slowTick | input | 1 | One-cycle strobe per slow RC oscillator period |
| opValid | input | 1 | Core presents an executed opcode |
| opCode | input | 8 | Opcode byte from the core |
| irqReq | input | N_IRQ | Interrupt request lines |
| irqEn | input | N_IRQ | Per-line interrupt enables |
| intEnable | input | 1 | Global interrupt enable |
| coreReset | output | 1 | Reset to the core, active high |
| cpuClkEn | output | 1 | CPU clock gate enable |
| oscEn | output | 1 | Main oscillator enable |
| restartAddr | output | VEC_W | Address the core starts from after reset |
| stateOh | output | 4 | One-hot state: run, halt, stop, reset-wait |

## Verification
The hardest case to reach from the ports is a restart of the delay partway through its count. The stimulus has to land a watchdog pulse between two particular slow ticks. The bench therefore drives `slowTick` by hand, one strobe at a time. It can then stop at any chosen count, fire the trigger, and count again up to TERM-1 to show that reset is still held. Stop-mode cases are reached by first sending the NOP-qualified stop opcode. Enabled interrupts are then applied while in stop, before each reset source is tried.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_STOP  = 2'd2,
    ST_RWAIT = 2'd3
  } rscState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic cntClear;     // restart delay count from zero
    logic cntLoadTerm;  // jump count to terminal (no delay)
    logic cntRun;       // count slow ticks
    logic decClear;     // forget the NOP history
    logic decRun;       // opcode stream is live
    logic vecSet;       // select stop-recovery vector
    logic vecClr;       // select cold vector
  } rscStrobe_t;

  localparam logic [7:0] OP_NOP  = 8'hFF;
  localparam logic [7:0] OP_HALT = 8'h7F;
  localparam logic [7:0] OP_STOP = 8'h6F;

endpackage

// File: rtl/rsc_datapath.sv
module rsc_datapath
  import rsc_pkg::*;
#(
  parameter int SLOW_HZ = 32768,
  parameter int DELAY_US = 5000,
  parameter int N_IRQ = 6,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] COLD_VEC = '0,
  parameter logic [VEC_W-1:0] STOP_VEC = 16'h000C
) (
  input  logic             clk,
  input  logic             porN,
  input  rscStrobe_t       strb,
  input  logic             slowTick,
  input  logic             opValid,
  input  logic [7:0]       opCode,
  input  logic [N_IRQ-1:0] irqReq,
  input  logic [N_IRQ-1:0] irqEn,
  input  logic             intEnable,
  output logic             cntDone,
  output logic             haltReq,
  output logic             stopReq,
  output logic             wakeIrq,
  output logic [VEC_W-1:0] restartAddr
);

  localparam longint TERM_L = (longint'(SLOW_HZ) * longint'(DELAY_US)) / 64'd1000000;
  localparam int TERM = (TERM_L < 1) ? 1 : int'(TERM_L);
  localparam int CNT_W = $clog2(TERM + 1);
  localparam logic [CNT_W-1:0] TERM_C = CNT_W'(TERM);

  // delay counter
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cnt <= '0;
    end else if (strb.cntClear) begin
      cnt <= '0;
    end else if (strb.cntLoadTerm) begin
      cnt <= TERM_C;
    end else if (strb.cntRun && slowTick && (cnt != TERM_C)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cntDone = (cnt == TERM_C);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!porN)
    cnt <= TERM_C); // R2

  AST_CNT_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!porN)
    ($past(!slowTick) && $past(!strb.cntClear) && $past(!strb.cntLoadTerm))
      |-> $stable(cnt)); // R2

  // opcode decode with NOP qualification
  logic prevNop;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      prevNop <= 1'b0;
    end else if (strb.decClear) begin
      prevNop <= 1'b0;
    end else if (strb.decRun && opValid) begin
      prevNop <= (opCode == OP_NOP);
    end
  end

  assign haltReq = strb.decRun && opValid && prevNop && (opCode == OP_HALT);
  assign stopReq = strb.decRun && opValid && prevNop && (opCode == OP_STOP);

  // interrupt qualification, one gate per line
  logic [N_IRQ-1:0] irqLive;

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : gIrq
    assign irqLive[gi] = irqReq[gi] & irqEn[gi];
  end

  assign wakeIrq = intEnable && (|irqLive);

  // restart vector select
  logic stopVec;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stopVec <= 1'b0;
    end else if (strb.vecClr) begin
      stopVec <= 1'b0;
    end else if (strb.vecSet) begin
      stopVec <= 1'b1;
    end
  end

  assign restartAddr = stopVec ? STOP_VEC : COLD_VEC;

endmodule

// File: rtl/rsc_control.sv
module rsc_control
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       powerGood,
  input  logic       extReset,
  input  logic       wdtTimeout,
  input  logic       stopRecover,
  input  logic       stopDelayEn,
  input  logic       cntDone,
  input  logic       haltReq,
  input  logic       stopReq,
  input  logic       wakeIrq,
  output rscStrobe_t strb,
  output rscState_t  curState
);

  rscState_t nextState;

  always_comb begin
    nextState        = curState;
    strb             = '0;
    strb.cntRun      = (curState == ST_RWAIT);
    strb.decRun      = (curState == ST_RUN);
    if (!powerGood) begin
      nextState     = ST_RWAIT;
      strb.cntClear = 1'b1;
      strb.decClear = 1'b1;
      strb.vecClr   = 1'b1;
    end else if (extReset) begin
      nextState        = ST_RWAIT;
      strb.cntLoadTerm = 1'b1;
      strb.decClear    = 1'b1;
      if (curState == ST_STOP) begin
        strb.vecSet = 1'b1;
      end else if (curState != ST_RWAIT) begin
        strb.vecClr = 1'b1;
      end
    end else if (wdtTimeout) begin
      nextState     = ST_RWAIT;
      strb.cntClear = 1'b1;
      strb.decClear = 1'b1;
      if (curState == ST_STOP) begin
        strb.vecSet = 1'b1;
      end else if (curState != ST_RWAIT) begin
        strb.vecClr = 1'b1;
      end
    end else begin
      unique case (curState)
        ST_RUN: begin
          if (stopReq) begin
            nextState = ST_STOP;
          end else if (haltReq) begin
            nextState = ST_HALT;
          end
        end
        ST_HALT: begin
          if (wakeIrq) begin
            nextState = ST_RUN;
          end
        end
        ST_STOP: begin
          if (stopRecover) begin
            nextState     = ST_RWAIT;
            strb.decClear = 1'b1;
            strb.vecSet   = 1'b1;
            if (stopDelayEn) begin
              strb.cntClear = 1'b1;
            end else begin
              strb.cntLoadTerm = 1'b1;
            end
          end
        end
        ST_RWAIT: begin
          if (cntDone) begin
            nextState = ST_RUN;
          end
        end
        default: nextState = ST_RWAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      curState <= ST_RWAIT;
    end else begin
      curState <= nextState;
    end
  end

  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!porN)
    (curState == ST_RUN && $past(curState) == ST_RWAIT) |-> $past(cntDone)); // R2

  AST_POWER_HOLD: assert property (@(posedge clk) disable iff (!porN)
    !powerGood |=> (curState == ST_RWAIT)); // R3

  AST_WDT_RESTARTS: assert property (@(posedge clk) disable iff (!porN)
    (powerGood && !extReset && wdtTimeout) |=> !cntDone); // R5

  AST_STOP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!porN)
    (curState == ST_STOP && $past(curState) != ST_STOP) |-> $past(stopReq)); // R7

  AST_HALT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!porN)
    (curState == ST_HALT && $past(curState) != ST_HALT) |-> $past(haltReq)); // R6

  AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!porN)
    (curState == ST_RUN && $past(curState) == ST_HALT) |-> $past(wakeIrq)); // R9

  AST_STOP_NO_IRQ_EXIT: assert property (@(posedge clk) disable iff (!porN)
    ($past(curState) == ST_STOP) |-> (curState != ST_RUN && curState != ST_HALT)); // R10

endmodule

// File: rtl/rstsleep_ctrl.sv
module rstsleep_ctrl
  import rsc_pkg::*;
#(
  parameter int SLOW_HZ = 32768,
  parameter int DELAY_US = 5000,
  parameter int N_IRQ = 6,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] COLD_VEC = '0,
  parameter logic [VEC_W-1:0] STOP_VEC = 16'h000C
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             powerGood,
  input  logic             extReset,
  input  logic             wdtTimeout,
  input  logic             stopRecover,
  input  logic             stopDelayEn,
  input  logic             slowTick,
  input  logic             opValid,
  input  logic [7:0]       opCode,
  input  logic [N_IRQ-1:0] irqReq,
  input  logic [N_IRQ-1:0] irqEn,
  input  logic             intEnable,
  output logic             coreReset,
  output logic             cpuClkEn,
  output logic             oscEn,
  output logic [VEC_W-1:0] restartAddr,
  output logic [3:0]       stateOh
);

  rscStrobe_t strb;
  rscState_t  curState;
  logic       cntDone;
  logic       haltReq;
  logic       stopReq;
  logic       wakeIrq;

  rsc_control uCtl (
    .clk        (clk),
    .porN       (porN),
    .powerGood  (powerGood),
    .extReset   (extReset),
    .wdtTimeout (wdtTimeout),
    .stopRecover(stopRecover),
    .stopDelayEn(stopDelayEn),
    .cntDone    (cntDone),
    .haltReq    (haltReq),
    .stopReq    (stopReq),
    .wakeIrq    (wakeIrq),
    .strb       (strb),
    .curState   (curState)
  );

  rsc_datapath #(
    .SLOW_HZ (SLOW_HZ),
    .DELAY_US(DELAY_US),
    .N_IRQ   (N_IRQ),
    .VEC_W   (VEC_W),
    .COLD_VEC(COLD_VEC),
    .STOP_VEC(STOP_VEC)
  ) uDp (
    .clk        (clk),
    .porN       (porN),
    .strb       (strb),
    .slowTick   (slowTick),
    .opValid    (opValid),
    .opCode     (opCode),
    .irqReq     (irqReq),
    .irqEn      (irqEn),
    .intEnable  (intEnable),
    .cntDone    (cntDone),
    .haltReq    (haltReq),
    .stopReq    (stopReq),
    .wakeIrq    (wakeIrq),
    .restartAddr(restartAddr)
  );

  assign stateOh   = {curState == ST_RWAIT, curState == ST_STOP,
                      curState == ST_HALT,  curState == ST_RUN};
  assign coreReset = (curState == ST_RWAIT);
  assign cpuClkEn  = (curState == ST_RUN) || (curState == ST_RWAIT);
  assign oscEn     = (curState != ST_STOP);

  AST_STOP_OSC_MATCH: assert property (@(posedge clk) disable iff (!porN)
    (!oscEn) |-> (!cpuClkEn && !coreReset)); // R7

endmodule

// File: tb/tb_rstsleep_ctrl.sv
module tb_rstsleep_ctrl;

  localparam int SLOW_HZ = 2000;
  localparam int DELAY_US = 5000;
  localparam int TERM = 10;          // 2000 Hz * 5 ms
  localparam int N_IRQ = 6;

  logic clk = 1'b0;
  logic porN, powerGood, extReset, wdtTimeout, stopRecover, stopDelayEn;
  logic slowTick, opValid, intEnable;
  logic [7:0] opCode;
  logic [N_IRQ-1:0] irqReq, irqEn;
  logic coreReset, cpuClkEn, oscEn;
  logic [15:0] restartAddr;
  logic [3:0] stateOh;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  rstsleep_ctrl #(.SLOW_HZ(SLOW_HZ), .DELAY_US(DELAY_US), .N_IRQ(N_IRQ)) dut (
    .clk(clk), .porN(porN), .powerGood(powerGood), .extReset(extReset),
    .wdtTimeout(wdtTimeout), .stopRecover(stopRecover), .stopDelayEn(stopDelayEn),
    .slowTick(slowTick), .opValid(opValid), .opCode(opCode), .irqReq(irqReq),
    .irqEn(irqEn), .intEnable(intEnable), .coreReset(coreReset),
    .cpuClkEn(cpuClkEn), .oscEn(oscEn), .restartAddr(restartAddr), .stateOh(stateOh)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    slowTick = 1'b1;
    cyc();
    slowTick = 1'b0;
  endtask

  task automatic op(logic [7:0] code);
    opValid = 1'b1;
    opCode = code;
    cyc();
    opValid = 1'b0;
    opCode = 8'h00;
  endtask

  task automatic pulseWdt();
    wdtTimeout = 1'b1;
    cyc();
    wdtTimeout = 1'b0;
  endtask

  // full delay from a fresh count: TERM-1 ticks hold, TERM-th tick then one edge releases
  task automatic fullDelay(string req);
    for (int i = 0; i < TERM - 1; i++) tick();
    check(req, "reset held before last tick", coreReset, 1'b1);
    tick();
    check(req, "reset held on last tick edge", coreReset, 1'b1);
    cyc();
    check(req, "released to run", stateOh, 4'b0001);
  endtask

  task automatic tReset();
    check("R1", "coreReset", coreReset, 1'b1);
    check("R1", "stateOh", stateOh, 4'b1000);
    check("R1", "cpuClkEn", cpuClkEn, 1'b1);
    check("R1", "oscEn", oscEn, 1'b1);
    check("R1", "restartAddr", restartAddr, 16'h0000);
  endtask

  task automatic tPowerUp();
    porN = 1'b1;
    cyc();
    repeat (3) cyc();
    check("R2", "no ticks no release", coreReset, 1'b1);
    fullDelay("R2");
    check("R2", "cold vector", restartAddr, 16'h0000);
  endtask

  task automatic tHalt();
    op(8'hFF);
    op(8'h7F);
    check("R6", "halt state", stateOh, 4'b0010);
    check("R6", "cpuClkEn off", cpuClkEn, 1'b0);
    check("R6", "oscEn on", oscEn, 1'b1);
    irqReq = 6'b000100; irqEn = 6'b111011; intEnable = 1'b1;
    repeat (2) cyc();
    check("R9", "masked line keeps halt", stateOh, 4'b0010);
    irqEn = 6'b111111; intEnable = 1'b0;
    repeat (2) cyc();
    check("R9", "global disable keeps halt", stateOh, 4'b0010);
    intEnable = 1'b1;
    cyc();
    check("R9", "wake to run", stateOh, 4'b0001);
    check("R9", "no reset on wake", coreReset, 1'b0);
    check("R9", "vector unchanged", restartAddr, 16'h0000);
    irqReq = '0;
  endtask

  task automatic tNoNop();
    op(8'h12);
    op(8'h7F);
    check("R8", "halt without nop ignored", stateOh, 4'b0001);
    op(8'h6F);
    check("R8", "stop without nop ignored", stateOh, 4'b0001);
    op(8'hFF);
    op(8'h00);
    op(8'h6F);
    check("R8", "nop not adjacent ignored", stateOh, 4'b0001);
  endtask

  task automatic enterStop(string req);
    op(8'hFF);
    op(8'h6F);
    check(req, "stop state", stateOh, 4'b0100);
  endtask

  task automatic tStopDelay();
    stopDelayEn = 1'b1;
    enterStop("R7");
    check("R7", "cpuClkEn off", cpuClkEn, 1'b0);
    check("R7", "oscEn off", oscEn, 1'b0);
    irqReq = 6'b111111; irqEn = 6'b111111; intEnable = 1'b1;
    repeat (3) cyc();
    check("R10", "irq ignored in stop", stateOh, 4'b0100);
    irqReq = '0;
    stopRecover = 1'b1;
    cyc();
    stopRecover = 1'b0;
    check("R11", "recovery enters reset", coreReset, 1'b1);
    check("R11", "stop vector", restartAddr, 16'h000C);
    fullDelay("R11");
  endtask

  task automatic tStopBypass();
    stopDelayEn = 1'b0;
    enterStop("R11");
    stopRecover = 1'b1;
    cyc();
    stopRecover = 1'b0;
    check("R11", "bypass one-cycle reset", coreReset, 1'b1);
    check("R11", "bypass vector", restartAddr, 16'h000C);
    cyc();
    check("R11", "bypass run", stateOh, 4'b0001);
  endtask

  task automatic tStopWdt();
    enterStop("R4");
    pulseWdt();
    check("R4", "wdt in stop vector", restartAddr, 16'h000C);
    fullDelay("R4");
  endtask

  task automatic tExt();
    enterStop("R12");
    extReset = 1'b1;
    repeat (4) cyc();
    check("R12", "held in reset", coreReset, 1'b1);
    check("R12", "vector from stop", restartAddr, 16'h000C);
    extReset = 1'b0;
    cyc();
    check("R12", "run after release", stateOh, 4'b0001);
    extReset = 1'b1;
    repeat (2) cyc();
    check("R12", "vector from run", restartAddr, 16'h0000);
    extReset = 1'b0;
    cyc();
    check("R12", "run again", coreReset, 1'b0);
  endtask

  task automatic tWdtRetrigger();
    pulseWdt();
    check("R4", "wdt in run resets", coreReset, 1'b1);
    check("R4", "wdt in run vector", restartAddr, 16'h0000);
    repeat (5) tick();
    pulseWdt();
    for (int i = 0; i < TERM - 1; i++) tick();
    check("R5", "retrigger still held", coreReset, 1'b1);
    tick();
    cyc();
    check("R5", "released after retrigger", stateOh, 4'b0001);
  endtask

  task automatic tPowerFail();
    powerGood = 1'b0;
    cyc();
    check("R3", "power fail resets", stateOh, 4'b1000);
    repeat (TERM + 2) tick();
    check("R3", "ticks ignored while power bad", coreReset, 1'b1);
    powerGood = 1'b1;
    fullDelay("R3");
    check("R3", "cold vector", restartAddr, 16'h0000);
  endtask

  initial begin
    porN = 1'b0; powerGood = 1'b1; extReset = 1'b0; wdtTimeout = 1'b0;
    stopRecover = 1'b0; stopDelayEn = 1'b1; slowTick = 1'b0; opValid = 1'b0;
    opCode = 8'h00; irqReq = '0; irqEn = '0; intEnable = 1'b0;
    repeat (3) @(negedge clk);
    tReset();
    tPowerUp();
    tHalt();
    tNoNop();
    tStopDelay();
    tStopBypass();
    tStopWdt();
    tExt();
    tWdtRetrigger();
    tPowerFail();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule